// File: doc/BRIEF.md
# Three-Wire Host Register Slave

This block is the slave end of a three-wire host bus: a bus clock, an active-low transaction strobe and one bidirectional data line. The host opens a transaction by pulling the strobe low and holds it low to the end. On the rising edges that follow, the host shifts in a direction flag, a broadcast flag and an 8-bit register address. A write then carries 16 data bits and a commit clock. A read has one turnaround clock, after which the slave shifts out 16 data bits on falling edges.

The block contains no register storage. Writes leave it through a page-select vector, a 5-bit offset and a data word. The register file that holds the values sits in the same bus-clock domain and captures them on the rising edge of the commit clock. Reads present the address combinationally and take the data back on a combinational read bus. The only register held inside the block is a fixed identification word. The data line is split into an input, an output value and an output enable, so the pad cell at the chip level does the actual tristating.

Top module: `host_serial_regif`

## Requirements
- R1: While reset is asserted, and after it with the strobe high, `sdata_oe` is 0 and `wr_sel` is all zeros.
- R2: In a transaction whose first bit is 0 (write), the page select goes high during clock 27, from the falling edge of clock 26 until the rising edge of clock 27. During the same window, `wr_offset` equals address bits 4:0 and `wr_data` equals the 16 bits sampled on clocks 11 to 26, first bit in bit 15.
- R3: For a non-broadcast write, address bits 7:5 select the page. Values 0 to 3 set `wr_sel[0]` to `wr_sel[3]` (the channel pages). Value 4 sets `wr_sel[4]` (the central page). Values 5 to 7 set no select bit.
- R4: When the second bit is 1 on a write, `wr_sel` is 5'b01111 whatever address bits 7:5 hold, and the offset is still address bits 4:0.
- R5: In a transaction whose first bit is 1 (read), `sdata_oe` is 0 through the falling edge of clock 11. From that edge `sdata_oe` is 1 and `sdata_out` carries read-data bit 15. Each later falling edge presents the next lower bit, so bit 0 appears from the falling edge of clock 26. `sdata_oe` returns to 0 at the falling edge of clock 27.
- R6: Address 83h reads 8010h whatever `rd_data` holds. A write to 83h sets no bit of `wr_sel`.
- R7: If the strobe rises before the commit clock of a write, no bit of `wr_sel` is set. If the strobe rises during read data, `sdata_oe` drops with it, without waiting for a clock edge.
- R8: `sdata_oe` stays 0 for the whole of every write transaction.
- R9: After the strobe has been high for two clocks, a new transaction starts again from bit 1.
- R10: On a read, the broadcast flag has no effect: the data returned is that of the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Host bus clock; may stop between transactions |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_n | input | 1 | Active-low transaction strobe |
| sdata_in | input | 1 | Data line as seen from the pad |
| sdata_out | output | 1 | Value driven onto the data line during read data |
| sdata_oe | output | 1 | Output enable for the data-line pad |
| rd_addr | output | 8 | Address of the register being read |
| rd_data | input | 16 | Combinational read data for `rd_addr` |
| wr_sel | output | 5 | Write strobes: bits 0-3 channel pages, bit 4 central page |
| wr_offset | output | 5 | Register offset within the selected page(s) |
| wr_data | output | 16 | Write data |

## Verification
The bench aims at the two edges where the bus direction changes. A slave that starts driving one clock early would collide with the host's last address bit. One that ends a clock late would still be driving when the host retakes the line. It also cuts transactions short at the last data bit and in the middle of read data: a design that commits on a counter without checking the strobe would write stale data, and one that waits for a clock to release the line would leave it driven with the bus clock stopped. Broadcast writes to central-page addresses, writes to the identification address, and reads with the broadcast flag set catch decoders that mix up the two flags or let the read-only word be overwritten.

// File: rtl/host_serial_regif.sv
module host_serial_regif #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int OFF_W  = 5,
  parameter int NCH    = 4,
  parameter int unsigned ID_ADDR = 'h83,
  parameter int unsigned ID_VAL  = 'h8010
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              strobe_n,
  input  logic              sdata_in,
  output logic              sdata_out,
  output logic              sdata_oe,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [NCH:0]      wr_sel,
  output logic [OFF_W-1:0]  wr_offset,
  output logic [DATA_W-1:0] wr_data
);
  localparam int HDR    = 2 + ADDR_W;
  localparam int LAST   = HDR + DATA_W;
  localparam int CNT_W  = $clog2(LAST + 2);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam logic [CNT_W-1:0] C_HDR  = CNT_W'(HDR);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(LAST);
  localparam logic [CNT_W-1:0] C_MAX  = '1;

  logic [CNT_W-1:0]  cnt;
  logic              rw_q, bc_q, oe_q, sdo_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] rd_val;
  logic [IDX_W-1:0]  ridx;
  logic [PAGE_W-1:0] page;
  logic              commit, is_id;

  assign is_id  = addr_q == ADDR_W'(ID_ADDR);
  assign rd_val = is_id ? DATA_W'(ID_VAL) : rd_data;
  assign ridx   = IDX_W'(C_LAST - cnt);
  assign page   = addr_q[ADDR_W-1:OFF_W];

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      rw_q   <= 1'b0;
      bc_q   <= 1'b0;
      addr_q <= '0;
      sh_q   <= '0;
    end else if (strobe_n) begin
      cnt <= '0;
    end else begin
      if (cnt != C_MAX) cnt <= cnt + 1'b1;
      if (cnt == '0) rw_q <= sdata_in;
      if (cnt == CNT_W'(1)) bc_q <= sdata_in;
      if (cnt >= CNT_W'(2) && cnt < C_HDR) addr_q <= {addr_q[ADDR_W-2:0], sdata_in};
      if (rw_q && cnt == C_HDR) sh_q <= rd_val;
      else if (!rw_q && cnt >= C_HDR && cnt < C_LAST) sh_q <= {sh_q[DATA_W-2:0], sdata_in};
    end
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      sdo_q <= 1'b0;
    end else begin
      oe_q  <= !strobe_n && rw_q && cnt > C_HDR && cnt <= C_LAST;
      sdo_q <= sh_q[ridx];
    end
  end

  assign sdata_oe  = oe_q & ~strobe_n;
  assign sdata_out = sdo_q;

  assign commit = !strobe_n && !rw_q && cnt == C_LAST;

  for (genvar g = 0; g < NCH; g++) begin : g_chsel
    assign wr_sel[g] = commit && (bc_q || page == PAGE_W'(g));
  end
  assign wr_sel[NCH] = commit && !bc_q && page == PAGE_W'(NCH) && !is_id;

  assign wr_offset = addr_q[OFF_W-1:0];
  assign wr_data   = sh_q;
  assign rd_addr   = addr_q;

  // R5 R8
  oe_only_on_read_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    oe_q |-> rw_q);

  // R8
  wr_never_on_read_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (|wr_sel) |-> !rw_q && !oe_q);

  // R2
  single_commit_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (|wr_sel) |=> !(|wr_sel));

  // R4
  bcast_all_pages_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (bc_q && (|wr_sel)) |-> $countones(wr_sel) == NCH && !wr_sel[NCH]);

  // R3
  page_unique_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !bc_q |-> $onehot0(wr_sel));

  // R6
  id_readonly_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    wr_sel[NCH] |-> !is_id);
endmodule

// File: tb/host_serial_regif_bench.sv
module host_serial_regif_bench;
  logic        clk = 1'b0;
  logic        rst_n, strobe_n, sdata_in;
  logic        sdata_out, sdata_oe;
  logic [7:0]  rd_addr;
  logic [15:0] rd_data;
  logic [4:0]  wr_sel, wr_offset;
  logic [15:0] wr_data;
  int vecs = 0;
  int errs = 0;

  always #5 clk = ~clk;

  assign rd_data = {rd_addr, ~rd_addr};

  host_serial_regif u_host_serial_regif (
    .sclk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .sdata_in(sdata_in),
    .sdata_out(sdata_out), .sdata_oe(sdata_oe), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_sel(wr_sel), .wr_offset(wr_offset), .wr_data(wr_data));

  function automatic logic [4:0] exp_sel(input logic bc, input logic [7:0] a);
    if (bc) return 5'b01111;
    if (a == 8'h83) return 5'b0;
    if (a[7:5] < 3'd5) return 5'b1 << a[7:5];
    return 5'b0;
  endfunction

  task automatic step(input logic stb, input logic b, input logic e_oe, input logic e_sdo,
                      input logic [4:0] e_sel, input logic [4:0] e_off,
                      input logic [15:0] e_dat, input string req);
    @(negedge clk);
    #1;
    strobe_n = stb;
    sdata_in = b;
    #3;
    vecs++;
    if (sdata_oe !== e_oe || (e_oe && sdata_out !== e_sdo) || wr_sel !== e_sel ||
        (e_sel != 5'b0 && (wr_offset !== e_off || wr_data !== e_dat))) begin
      errs++;
      $display("FAIL %s: oe=%b sdo=%b sel=%b off=%h dat=%h expected oe=%b sdo=%b sel=%b off=%h dat=%h",
               req, sdata_oe, sdata_out, wr_sel, wr_offset, wr_data,
               e_oe, e_sdo, e_sel, e_off, e_dat);
    end
  endtask

  task automatic txn(input logic rw, input logic bc, input logic [7:0] a,
                     input logic [15:0] d, input int len, input string req);
    logic [15:0] rdval = (a == 8'h83) ? 16'h8010 : {a, ~a};
    for (int k = 1; k <= 27; k++) begin
      logic low = k <= len;
      logic b = 1'b0;
      logic e_oe;
      if (k == 1) b = rw;
      else if (k == 2) b = bc;
      else if (k <= 10) b = a[10-k];
      else if (!rw && k <= 26) b = d[26-k];
      e_oe = low && rw && k >= 12;
      step(!low, low ? b : 1'b0, e_oe, e_oe ? rdval[27-k] : 1'b0,
           (low && !rw && k == 27) ? exp_sel(bc, a) : 5'b0, a[4:0], d, req);
    end
    step(1'b1, 1'b0, 1'b0, 1'b0, 5'b0, 5'b0, 16'h0, "R9 idle");
    step(1'b1, 1'b0, 1'b0, 1'b0, 5'b0, 5'b0, 16'h0, "R9 idle");
  endtask

  initial begin
    #100000;
    errs++;
    $display("FAIL R9 watchdog: run still active, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    strobe_n = 1'b1;
    sdata_in = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 5'b0, 5'b0, 16'h0, "R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 2; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 5'b0, 5'b0, 16'h0, "R1 idle");
    txn(1'b0, 1'b0, 8'h05, 16'hA5C3, 27, "R2 write ch0");
    txn(1'b0, 1'b0, 8'h3F, 16'h0001, 27, "R3 page1");
    txn(1'b0, 1'b0, 8'h5A, 16'h8000, 27, "R3 page2");
    txn(1'b0, 1'b0, 8'h7F, 16'hFFFF, 27, "R3 page3");
    txn(1'b0, 1'b0, 8'h81, 16'h1234, 27, "R3 central");
    txn(1'b0, 1'b0, 8'hA4, 16'h5555, 27, "R3 unmapped");
    txn(1'b0, 1'b1, 8'h92, 16'hBEEF, 27, "R4 broadcast");
    txn(1'b0, 1'b1, 8'h07, 16'h0F0F, 27, "R4 broadcast low");
    txn(1'b0, 1'b0, 8'h83, 16'hDEAD, 27, "R6 id write");
    txn(1'b1, 1'b0, 8'h45, 16'h0, 27, "R5 read");
    txn(1'b1, 1'b0, 8'h83, 16'h0, 27, "R6 id read");
    txn(1'b1, 1'b1, 8'h10, 16'h0, 27, "R10 read bcast");
    txn(1'b0, 1'b0, 8'h22, 16'hCAFE, 26, "R7 write abort");
    txn(1'b1, 1'b0, 8'h66, 16'h0, 15, "R7 read abort");
    txn(1'b0, 1'b0, 8'h09, 16'h7E81, 27, "R8 R9 after abort");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule